// File: doc/BRIEF.md
# Three-level vectored interrupt priority controller

This block sits between a group of peripheral interrupt sources and a small CPU core. Fourteen request flags, each gated by its own enable bit, are folded onto ten vectors. Some vectors serve two sources. Each vector carries a priority level chosen by software: low, high or highest. Only the first two vectors may use the highest level. Every cycle the block picks one winner among the enabled requests. It presents that vector's address together with a pending flag, registered one clock after the request is seen.

The block also tracks which handler levels are in service. When the CPU acknowledges a pending interrupt, the level of that interrupt becomes the active level. A return strobe restores the level that was active before. A running handler can be pre-empted only by a request whose level is strictly above the active one. Requests at the same or a lower level wait until the active level falls.

Top module: `intc_prio_ctrl`

## Requirements
- R1: After reset, irq_pend is 0, vec_addr is 0 and act_lvl is 0.
- R2: Vector k (k = 0..9) has the 17-bit address 0x03 + 8*k, so the addresses run from 0x00003 to 0x0004B. vec_addr shows the winner's address while irq_pend is 1 and is 0 while irq_pend is 0. Both reflect the inputs of the previous clock cycle.
- R3: Sources map to vectors as follows: src 0 to vector 0, src 1 to vector 1, src 2 and 3 to vector 2, src 4 and 5 to vector 3, src 6 to vector 4, src 7 and 8 to vector 5, src 9 to vector 6, src 10 to vector 7, src 11 and 12 to vector 8, src 13 to vector 9. A source counts only while its bit in src_en is 1.
- R4: Vector k is configured by lvl_sel[2k+1:2k]. On vectors 0 and 1, bit 1 set selects the highest level whatever bit 0 holds. Otherwise bit 0 = 1 selects high and bit 0 = 0 selects low. Bit 1 has no effect on vectors 2..9. act_lvl encodes 0 = idle, 1 = low, 2 = high, 3 = highest.
- R5: Among eligible requests the highest level wins. Among equal levels the lowest vector index, which is also the lowest address, wins.
- R6: With act_lvl = 0, any enabled request of any level raises irq_pend.
- R7: With act_lvl = L > 0, only requests with level above L raise irq_pend. Requests at L or below stay held until the active level drops.
- R8: ack while irq_pend = 1 makes the pending level the new act_lvl on the next cycle and forces irq_pend to 0 for that cycle. ack while irq_pend = 0 has no effect.
- R9: ret restores the previous act_lvl, or 0 when one handler was active. ret with act_lvl = 0 has no effect. ret in the same cycle as an accepted ack is ignored.
- R10: The level given on lvl_sel is used by the arbitration at the same clock edge. A change to the level of a waiting vector is therefore visible on irq_pend one cycle later.
- R11: Nesting of low, then high, then highest handlers is held three deep and unwinds in reverse order through successive returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 14 | Per-source request flags |
| src_en | input | 14 | Per-source enable bits |
| lvl_sel | input | 20 | Two level-select bits per vector |
| ack | input | 1 | CPU acknowledge of the pending interrupt |
| ret | input | 1 | Return-from-interrupt strobe |
| irq_pend | output | 1 | An interrupt is offered to the CPU |
| vec_addr | output | 17 | Address of the offered vector, 0 when none |
| act_lvl | output | 2 | Level of the handler in service, 0 when idle |

## Verification
The assertions assume that the CPU acknowledges only what the block offers and returns only from handlers it entered. Under that assumption the in-service stack can never be pushed past three entries, and every push is strictly above the current top. The random stimulus keeps to this by issuing ret only while the bench's own model holds a handler. Acknowledges are issued freely, since one that arrives with nothing pending is dropped by design. Level selections and request patterns change at random on every cycle, so level changes on waiting vectors and ties between vectors are exercised as well.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int MAP_W = 4;

   localparam logic [1:0] LV_IDLE = 2'd0;
   localparam logic [1:0] LV_LOW  = 2'd1;
   localparam logic [1:0] LV_HIGH = 2'd2;
   localparam logic [1:0] LV_TOP  = 2'd3;

   // source n occupies bits [4n+3:4n]; value = vector index
   localparam logic [14*MAP_W-1:0] DEF_SRC_MAP = {
      4'd9, 4'd8, 4'd8, 4'd7, 4'd6, 4'd5, 4'd5,
      4'd4, 4'd3, 4'd3, 4'd2, 4'd2, 4'd1, 4'd0 };

   function automatic logic [MAP_W-1:0] lowest_idx(input logic [15:0] m);
      lowest_idx = '0;
      for (int i = 15; i >= 0; i--) begin
         if (m[i]) lowest_idx = MAP_W'(i);
      end
   endfunction

endpackage

// File: rtl/intc_src_merge.sv
module intc_src_merge
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 14,
   parameter int NUM_VEC = 10,
   parameter logic [NUM_SRC*MAP_W-1:0] SRC_MAP = DEF_SRC_MAP
) (
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] src_en,
   output logic [NUM_VEC-1:0] vec_req
);

   logic [NUM_SRC-1:0] live;
   assign live = src_req & src_en;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (SRC_MAP[s*MAP_W +: MAP_W] == MAP_W'(v)) hit = hit | live[s];
         end
      end
      assign vec_req[v] = hit;
   end

endmodule

// File: rtl/intc_level_map.sv
module intc_level_map
   import intc_pkg::*;
#(
   parameter int NUM_VEC     = 10,
   parameter int NUM_TOP_VEC = 2
) (
   input  logic [2*NUM_VEC-1:0] lvl_sel,
   output logic [2*NUM_VEC-1:0] vec_lvl
);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      logic [1:0] sel;
      assign sel = lvl_sel[2*v +: 2];
      if (v < NUM_TOP_VEC) begin : g_top
         assign vec_lvl[2*v +: 2] = sel[1] ? LV_TOP : (sel[0] ? LV_HIGH : LV_LOW);
      end else begin : g_std
         assign vec_lvl[2*v +: 2] = sel[0] ? LV_HIGH : LV_LOW;
      end
   end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
   import intc_pkg::*;
#(
   parameter int NUM_VEC = 10
) (
   input  logic [NUM_VEC-1:0]   vec_req,
   input  logic [2*NUM_VEC-1:0] vec_lvl,
   input  logic [1:0]           cur_lvl,
   output logic                 win_valid,
   output logic [MAP_W-1:0]     win_idx,
   output logic [1:0]           win_lvl
);

   logic [3:1]       lv_hit;
   logic [MAP_W-1:0] lv_idx [3:1];

   for (genvar l = 1; l <= 3; l++) begin : g_lvl
      logic [15:0] m;
      always_comb begin
         m = '0;
         for (int v = 0; v < NUM_VEC; v++) begin
            m[v] = vec_req[v] && (vec_lvl[2*v +: 2] == 2'(l)) && (2'(l) > cur_lvl);
         end
      end
      assign lv_hit[l] = |m;
      assign lv_idx[l] = lowest_idx(m);
   end

   always_comb begin
      win_valid = 1'b1;
      if (lv_hit[3]) begin
         win_idx = lv_idx[3];
         win_lvl = LV_TOP;
      end else if (lv_hit[2]) begin
         win_idx = lv_idx[2];
         win_lvl = LV_HIGH;
      end else if (lv_hit[1]) begin
         win_idx = lv_idx[1];
         win_lvl = LV_LOW;
      end else begin
         win_valid = 1'b0;
         win_idx   = '0;
         win_lvl   = LV_IDLE;
      end
   end

endmodule

// File: rtl/intc_nest_stack.sv
module intc_nest_stack
   import intc_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic [1:0] push_lvl,
   input  logic       pop,
   output logic [1:0] top_lvl
);

   logic [1:0] stk [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [1:0] from_above;
      logic [1:0] from_below;
      if (i == 0) begin : g_first
         assign from_above = push_lvl;
      end else begin : g_mid
         assign from_above = stk[i-1];
      end
      if (i == DEPTH-1) begin : g_last
         assign from_below = LV_IDLE;
      end else begin : g_rest
         assign from_below = stk[i+1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)    stk[i] <= LV_IDLE;
         else if (push) stk[i] <= from_above;
         else if (pop)  stk[i] <= from_below;
      end
   end

   assign top_lvl = stk[0];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> stk[DEPTH-1] == LV_IDLE);                          // R11
   AST_STRICT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> push_lvl > stk[0]);                                 // R7
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && stk[0] == LV_IDLE) |=> stk[0] == LV_IDLE);  // R9

endmodule

// File: rtl/intc_prio_ctrl.sv
module intc_prio_ctrl
   import intc_pkg::*;
#(
   parameter int NUM_SRC     = 14,
   parameter int NUM_VEC     = 10,
   parameter int NUM_TOP_VEC = 2,
   parameter int NEST_DEPTH  = 3,
   parameter int ADDR_W      = 17,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STEP    = 8,
   parameter logic [NUM_SRC*MAP_W-1:0] SRC_MAP = DEF_SRC_MAP
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   src_req,
   input  logic [NUM_SRC-1:0]   src_en,
   input  logic [2*NUM_VEC-1:0] lvl_sel,
   input  logic                 ack,
   input  logic                 ret,
   output logic                 irq_pend,
   output logic [ADDR_W-1:0]    vec_addr,
   output logic [1:0]           act_lvl
);

   localparam longint LAST_ADDR = longint'(VEC_BASE) + longint'(NUM_VEC-1) * longint'(VEC_STEP);

   if (NUM_VEC > 16) begin : g_chk_vec
      $error("NUM_VEC exceeds the 16 vectors the index field holds");
   end
   if (NUM_TOP_VEC > NUM_VEC) begin : g_chk_top
      $error("NUM_TOP_VEC larger than NUM_VEC");
   end
   if (NEST_DEPTH < 3) begin : g_chk_depth
      $error("NEST_DEPTH must cover the three priority levels");
   end
   if (LAST_ADDR >= (longint'(1) << ADDR_W)) begin : g_chk_addr
      $error("vector addresses do not fit in ADDR_W");
   end

   logic [NUM_VEC-1:0]   vec_req;
   logic [2*NUM_VEC-1:0] vec_lvl;
   logic                 win_valid;
   logic [MAP_W-1:0]     win_idx;
   logic [1:0]           win_lvl;
   logic                 pend_q;
   logic [MAP_W-1:0]     pend_idx_q;
   logic [1:0]           pend_lvl_q;
   logic                 take;

   intc_src_merge #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .SRC_MAP(SRC_MAP)) i_merge (
      .src_req (src_req),
      .src_en  (src_en),
      .vec_req (vec_req)
   );

   intc_level_map #(.NUM_VEC(NUM_VEC), .NUM_TOP_VEC(NUM_TOP_VEC)) i_lvlmap (
      .lvl_sel (lvl_sel),
      .vec_lvl (vec_lvl)
   );

   intc_arbiter #(.NUM_VEC(NUM_VEC)) i_arb (
      .vec_req   (vec_req),
      .vec_lvl   (vec_lvl),
      .cur_lvl   (act_lvl),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_lvl   (win_lvl)
   );

   assign take = ack && pend_q;

   intc_nest_stack #(.DEPTH(NEST_DEPTH)) i_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .push_lvl (pend_lvl_q),
      .pop      (ret && !take),
      .top_lvl  (act_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || take) begin
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
         pend_lvl_q <= LV_IDLE;
      end else begin
         pend_q     <= win_valid;
         pend_idx_q <= win_idx;
         pend_lvl_q <= win_lvl;
      end
   end

   assign irq_pend = pend_q;
   assign vec_addr = pend_q ? (ADDR_W'(VEC_BASE) + ADDR_W'(pend_idx_q) * ADDR_W'(VEC_STEP))
                            : '0;

   AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pend |-> vec_addr == '0);                                          // R2
   AST_PEND_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend |-> pend_lvl_q > act_lvl);                                     // R7
   AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (act_lvl == $past(pend_lvl_q)) && !irq_pend);                  // R8
   AST_RET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !take && act_lvl != LV_IDLE) |=> act_lvl < $past(act_lvl));     // R9
   AST_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && pend_lvl_q == LV_TOP) |-> pend_idx_q < MAP_W'(NUM_TOP_VEC)); // R4

endmodule

// File: tb/test_intc_prio_ctrl.sv
`timescale 1ns/1ps
module test_intc_prio_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] src_req = '0;
   logic [13:0] src_en = '0;
   logic [19:0] lvl_sel = '0;
   logic        ack = 1'b0;
   logic        ret = 1'b0;
   logic        irq_pend;
   logic [16:0] vec_addr;
   logic [1:0]  act_lvl;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int exp_pend = 0;
   int exp_idx = 0;
   int exp_plvl = 0;
   int mstk [3];
   int mdepth = 0;

   always #4 clk = ~clk;

   intc_prio_ctrl i_intc_prio_ctrl (
      .clk (clk), .rst_n (rst_n), .src_req (src_req), .src_en (src_en),
      .lvl_sel (lvl_sel), .ack (ack), .ret (ret),
      .irq_pend (irq_pend), .vec_addr (vec_addr), .act_lvl (act_lvl)
   );

   function automatic int vec_of(int s);
      case (s)
         0: return 0;  1: return 1;  2, 3: return 2;  4, 5: return 3;
         6: return 4;  7, 8: return 5;  9: return 6;  10: return 7;
         11, 12: return 8;  default: return 9;
      endcase
   endfunction

   function automatic int lvl_of(int v, logic [19:0] ls);
      if (v < 2 && ls[2*v+1]) return 3;
      return ls[2*v] ? 2 : 1;
   endfunction

   function automatic int cur_act();
      return (mdepth > 0) ? mstk[mdepth-1] : 0;
   endfunction

   function automatic logic [19:0] put_lvl(logic [19:0] ls, int v, logic [1:0] val);
      logic [19:0] r = ls;
      r[2*v +: 2] = val;
      return r;
   endfunction

   task automatic chk(string tag, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
      end
   endtask

   task automatic cyc(logic [13:0] rq, logic [13:0] en, logic [19:0] ls,
                      logic a, logic r, string tag);
      int cur;
      src_req = rq; src_en = en; lvl_sel = ls; ack = a; ret = r;
      cur = cur_act();
      if (a && exp_pend != 0) begin
         mstk[mdepth] = exp_plvl;
         mdepth++;
         exp_pend = 0; exp_idx = 0; exp_plvl = 0;
      end else begin
         int bl = 0;
         int bi = 0;
         if (r && mdepth > 0) mdepth--;
         for (int v = 9; v >= 0; v--) begin
            bit live = 0;
            for (int s = 0; s < 14; s++)
               if (rq[s] && en[s] && vec_of(s) == v) live = 1;
            if (live && lvl_of(v, ls) > cur && lvl_of(v, ls) >= bl) begin
               bl = lvl_of(v, ls); bi = v;
            end
         end
         exp_pend = (bl > 0) ? 1 : 0; exp_idx = bi; exp_plvl = bl;
      end
      @(posedge clk);
      @(negedge clk);
      ack = 1'b0; ret = 1'b0;
      chk(tag, "irq_pend", int'(irq_pend), exp_pend);
      chk(tag, "vec_addr", int'(vec_addr), exp_pend != 0 ? 3 + 8 * exp_idx : 0);
      chk(tag, "act_lvl", int'(act_lvl), cur_act());
   endtask

   localparam logic [13:0] ALL = 14'h3FFF;

   initial begin
      logic [19:0] ls;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "irq_pend", int'(irq_pend), 0);
      chk("R1", "vec_addr", int'(vec_addr), 0);
      chk("R1", "act_lvl", int'(act_lvl), 0);

      // source to vector mapping, each source alone
      for (int s = 0; s < 14; s++) begin
         cyc(14'(1 << s), ALL, '0, 0, 0, "R3");
         chk("R3", "mapped addr", int'(vec_addr), 3 + 8 * vec_of(s));
      end
      cyc(ALL, '0, '0, 0, 0, "R3");
      cyc(14'h2000, ALL, '0, 0, 0, "R2");
      chk("R2", "last vector addr", int'(vec_addr), 'h4B);
      cyc(14'h0001, ALL, '0, 0, 0, "R2");
      chk("R2", "first vector addr", int'(vec_addr), 'h03);
      cyc(14'h0000, ALL, '0, 0, 0, "R2");

      // priority and tie break
      ls = put_lvl(put_lvl('0, 4, 2'b01), 7, 2'b01);
      cyc(14'h0440, ALL, ls, 0, 0, "R5");
      chk("R5", "tie lowest addr", int'(vec_addr), 3 + 8 * 4);
      ls = put_lvl('0, 9, 2'b01);
      cyc(14'h2004, ALL, ls, 0, 0, "R5");
      chk("R5", "higher level wins", int'(vec_addr), 'h4B);
      ls = put_lvl(put_lvl('0, 0, 2'b10), 1, 2'b10);
      cyc(14'h0003, ALL, ls, 0, 0, "R5");

      // idle accepts low, acknowledge semantics
      cyc(14'h2000, ALL, '0, 0, 0, "R6");
      chk("R6", "low accepted when idle", int'(irq_pend), 1);
      cyc(14'h2000, ALL, '0, 1, 0, "R8");
      chk("R8", "act after ack", int'(act_lvl), 1);
      cyc(14'h0000, ALL, '0, 1, 0, "R8");

      // held requests under a low handler, level change one cycle later
      cyc(14'h0040, ALL, '0, 0, 0, "R7");
      chk("R7", "equal level held", int'(irq_pend), 0);
      ls = put_lvl('0, 4, 2'b01);
      cyc(14'h0040, ALL, ls, 0, 0, "R10");
      chk("R10", "raised level seen", int'(irq_pend), 1);
      cyc(14'h0040, ALL, ls, 1, 0, "R11");
      chk("R11", "second level", int'(act_lvl), 2);

      // bit 1 on a non-top vector is no promotion
      ls = put_lvl('0, 2, 2'b10);
      cyc(14'h0004, ALL, ls, 0, 0, "R4");
      chk("R4", "bit1 ignored on vector 2", int'(irq_pend), 0);
      ls = put_lvl('0, 1, 2'b10);
      cyc(14'h0002, ALL, ls, 0, 0, "R4");
      chk("R4", "vector 1 highest", int'(vec_addr), 'h0B);
      cyc(14'h0002, ALL, ls, 1, 1, "R9");
      chk("R9", "ret with ack ignored", int'(act_lvl), 3);
      cyc(14'h0000, ALL, '0, 0, 1, "R11");
      chk("R11", "unwind to high", int'(act_lvl), 2);
      cyc(14'h0000, ALL, '0, 0, 1, "R11");
      chk("R11", "unwind to low", int'(act_lvl), 1);
      cyc(14'h0000, ALL, '0, 0, 1, "R9");
      chk("R9", "unwind to idle", int'(act_lvl), 0);
      cyc(14'h0000, ALL, '0, 0, 1, "R9");
      chk("R9", "ret when idle", int'(act_lvl), 0);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [13:0] rq = 14'($urandom) & 14'($urandom);
         logic [13:0] en = 14'($urandom) | 14'($urandom);
         logic [19:0] lr = 20'($urandom);
         logic a = ($urandom % 4) == 0;
         logic r = (mdepth > 0) && (($urandom % 5) == 0);
         cyc(rq, en, lr, a, r, "random R5 R7");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got hung exp finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule